// File: doc/BRIEF.md
# PLL Stabilization Wait Timer

This block holds back the ready indication of a phase-locked loop until the loop has had time to settle. A small 8-bit configuration register selects the length of the hold-off as a power-of-two exponent code and also chooses which reference oscillator feeds the PLL. When the PLL enable input rises, a counter starts counting ticks of a fast internal reference clock. The ticks arrive as a clock-enable pulse in the system clock domain. Once the programmed number of ticks has been seen, the ready flag goes high, and it stays high for as long as the enable stays high.

The configuration keeps its contents through a software reset and is cleared only by the asynchronous power-on reset. Both resets abort a wait in progress. The wait length is captured at the moment the wait starts, so a later write does not disturb a wait already under way. The wait length is `2^(BASE_EXP+n)` ticks for code `n`. `BASE_EXP` defaults to 9, which gives 512 to 65536 ticks.

Top module: `pll_wait_timer`

## Requirements
- R1: While `por_n` is low, and right after it is released, `rd_data` reads 0, `src_sel` is 0 and `pll_ready` is 0.
- R2: The register field layout is fixed:
  - Bits [2:0] hold the wait code and bit 4 holds the source choice.
  - A write with `wr_en` high at a clock edge is visible on `rd_data` after that edge.
- R3: Bits 7:5 and bit 3 always read 0, whatever value is written to them.
- R4: `src_sel` equals the stored bit 4: 0 selects the crystal oscillator and 1 selects the internal RC clock.
- R5: The length of a wait is exact:
  - A wait starts at the first clock edge that samples `pll_en` high after it was sampled low, or after a reset. A tick sampled at that edge is not counted.
  - `pll_ready` rises after the edge that samples the `2^(BASE_EXP+n)`-th counted `ref_tick`, and not before.
- R6: Once high, `pll_ready` stays high while `pll_en` stays high and no reset occurs.
- R7: `pll_ready` goes low in the same cycle that `pll_en` goes low, and a later rise of `pll_en` starts a fresh wait.
- R8: The wait length is taken from the code stored at the start edge. A write during the wait does not change the length of that wait.
- R9: Asserting `sw_rst` leaves the register contents unchanged.
- R10: `sw_rst` aborts any wait and clears `pll_ready` from the following edge. If `pll_en` is still high, a fresh full wait starts at the first edge with `sw_rst` low.
- R11: Pulling `por_n` low clears the register and drops `pll_ready` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sw_rst | input | 1 | Synchronous software reset, active high |
| ref_tick | input | 1 | One-cycle pulse per reference-clock period |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value |
| pll_en | input | 1 | PLL enable |
| pll_ready | output | 1 | PLL stabilization complete |
| src_sel | output | 1 | PLL input source select |

## Verification
The bench builds the block with `BASE_EXP` set to 2, so the eight codes give waits of 4 to 512 ticks. This short range lets every code be run to completion, together with many randomized waits with irregular tick spacing, in a few thousand cycles. The exponent arithmetic and the tick comparison are the same for any base, so the off-by-one behaviour at the terminal count is exercised exactly as it would be at the default base. The counter width is derived from the parameter, so the widest code still uses the top counter bit.

// File: rtl/pll_wait_pkg.sv
package pll_wait_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned CODE_LSB = 0;
  localparam int unsigned SRC_BIT  = 4;

  // Number of reference ticks for a given wait code
  function automatic int unsigned wait_cycles(input int unsigned base_exp,
                                              input int unsigned code);
    return 32'd1 << (base_exp + code);
  endfunction

  // Bits that hold storage; all others are reserved and read zero
  function automatic logic [REG_W-1:0] write_mask(input int unsigned code_w);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < int'(code_w); i++) m[CODE_LSB + i] = 1'b1;
    m[SRC_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/pwt_cfg_reg.sv
module pwt_cfg_reg #(
  parameter int unsigned CODE_W = 3
) (
  input  logic                           clk,
  input  logic                           por_n,
  input  logic                           wr_en,
  input  logic [pll_wait_pkg::REG_W-1:0] wr_data,
  output logic [pll_wait_pkg::REG_W-1:0] cfg_q,
  output logic [CODE_W-1:0]              code,
  output logic                           src
);
  localparam logic [pll_wait_pkg::REG_W-1:0] MASK = pll_wait_pkg::write_mask(CODE_W);

  // Only power-on reset clears the configuration
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= wr_data & MASK;
  end

  assign code = cfg_q[pll_wait_pkg::CODE_LSB +: CODE_W];
  assign src  = cfg_q[pll_wait_pkg::SRC_BIT];
endmodule

// File: rtl/pwt_en_edge.sv
module pwt_en_edge (
  input  logic clk,
  input  logic por_n,
  input  logic sw_rst,
  input  logic pll_en,
  output logic start
);
  logic en_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      en_q <= 1'b0;
    else if (sw_rst) en_q <= 1'b0;
    else             en_q <= pll_en;
  end

  assign start = pll_en & ~en_q & ~sw_rst;
endmodule

// File: rtl/pwt_wait_cnt.sv
module pwt_wait_cnt #(
  parameter int unsigned CODE_W   = 3,
  parameter int unsigned BASE_EXP = 9,
  parameter int unsigned CNT_W    = BASE_EXP + (1 << CODE_W)
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sw_rst,
  input  logic              pll_en,
  input  logic              start,
  input  logic              ref_tick,
  input  logic [CODE_W-1:0] code,
  output logic              active,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  limit,
  output logic              done
);
  logic [CNT_W-1:0] limit_d;
  logic [CNT_W-1:0] cnt_inc;

  assign limit_d = CNT_W'(pll_wait_pkg::wait_cycles(BASE_EXP, 32'(code)));
  assign cnt_inc = cnt + 1'b1;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      active <= 1'b0;
      cnt    <= '0;
      limit  <= '0;
      done   <= 1'b0;
    end else if (sw_rst || !pll_en) begin
      active <= 1'b0;
      cnt    <= '0;
      done   <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
      limit  <= limit_d;
      done   <= 1'b0;
    end else if (active && ref_tick && !done) begin
      cnt <= cnt_inc;
      if (cnt_inc == limit) done <= 1'b1;
    end
  end
endmodule

// File: rtl/pll_wait_timer.sv
module pll_wait_timer #(
  parameter int unsigned CODE_W   = 3,
  parameter int unsigned BASE_EXP = 9
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       sw_rst,
  input  logic       ref_tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       pll_en,
  output logic       pll_ready,
  output logic       src_sel
);
  localparam int unsigned CNT_W = BASE_EXP + (1 << CODE_W);

  logic [7:0]        cfg_q;
  logic [CODE_W-1:0] code;
  logic              src;
  logic              start;
  logic              active;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  limit;
  logic              done;

  pwt_cfg_reg #(.CODE_W(CODE_W)) u_cfg (
    .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_q(cfg_q), .code(code), .src(src)
  );

  pwt_en_edge u_edge (
    .clk(clk), .por_n(por_n), .sw_rst(sw_rst), .pll_en(pll_en), .start(start)
  );

  pwt_wait_cnt #(.CODE_W(CODE_W), .BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .por_n(por_n), .sw_rst(sw_rst), .pll_en(pll_en), .start(start),
    .ref_tick(ref_tick), .code(code), .active(active), .cnt(cnt),
    .limit(limit), .done(done)
  );

  assign rd_data   = cfg_q;
  assign src_sel   = src;
  assign pll_ready = done & pll_en;
endmodule

// File: rtl/pll_wait_timer_chk.sv
module pll_wait_timer_chk #(
  parameter int unsigned CODE_W = 3,
  parameter int unsigned CNT_W  = 17
) (
  input logic             clk,
  input logic             por_n,
  input logic             sw_rst,
  input logic             ref_tick,
  input logic             wr_en,
  input logic [7:0]       wr_data,
  input logic [7:0]       rd_data,
  input logic             pll_en,
  input logic             pll_ready,
  input logic             start,
  input logic             active,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] limit
);
  localparam logic [7:0] MASK = pll_wait_pkg::write_mask(CODE_W);

  assert_write_visible_R2: assert property (@(posedge clk) disable iff (!por_n)
    wr_en |=> rd_data == ($past(wr_data) & MASK));

  assert_keep_on_swrst_R9: assert property (@(posedge clk) disable iff (!por_n)
    (sw_rst && !wr_en) |=> $stable(rd_data));

  assert_ready_on_tick_R5: assert property (@(posedge clk) disable iff (!por_n)
    $rose(pll_ready) |-> $past(ref_tick) && $past(active));

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!por_n)
    active |-> cnt <= limit);

  assert_start_clears_R7: assert property (@(posedge clk) disable iff (!por_n)
    start |=> (cnt == '0) && !pll_ready);

  assert_swrst_aborts_R10: assert property (@(posedge clk) disable iff (!por_n)
    sw_rst |=> !pll_ready && !active);
endmodule

bind pll_wait_timer pll_wait_timer_chk #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .por_n(por_n), .sw_rst(sw_rst), .ref_tick(ref_tick),
  .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .pll_en(pll_en),
  .pll_ready(pll_ready), .start(start), .active(active), .cnt(cnt),
  .limit(limit)
);

// File: tb/pll_wait_timer_tb.sv
module pll_wait_timer_tb;
  localparam int unsigned TB_BASE = 2;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       sw_rst = 1'b0;
  logic       ref_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       pll_en = 1'b0;
  logic       pll_ready;
  logic       src_sel;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  pll_wait_timer #(.CODE_W(3), .BASE_EXP(TB_BASE)) u_dut (
    .clk(clk), .por_n(por_n), .sw_rst(sw_rst), .ref_tick(ref_tick),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .pll_en(pll_en),
    .pll_ready(pll_ready), .src_sel(src_sel)
  );

  function automatic int exp_len(input int code);
    int v = 1;
    for (int i = 0; i < TB_BASE + code; i++) v = v * 2;
    return v;
  endfunction

  function automatic logic [7:0] exp_read(input logic [7:0] w);
    return {3'b000, w[4], 1'b0, w[2:0]};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // Next posedge is the start edge; counts ticks and compares pll_ready every cycle
  task automatic wait_run(input int len, input bit mid_write, input string req);
    int given = 0;
    bit wrote = 0;
    bit bad = 0;
    int bad_given = 0;
    int bad_val = 0;
    bit t;
    ref_tick = 1'b0;
    @(posedge clk);
    while (1) begin
      @(negedge clk);
      wr_en = 1'b0;
      if (!bad && (pll_ready !== (given >= len))) begin
        bad = 1; bad_given = given; bad_val = int'(pll_ready);
      end
      if (given >= len + 3) break;
      t = (($urandom % 4) != 0);
      ref_tick = t;
      if (mid_write && !wrote && given == len / 2) begin
        wrote = 1; wr_en = 1'b1; wr_data = 8'($urandom);
      end
      @(posedge clk);
      if (t) given++;
    end
    ref_tick = 1'b0;
    check(!bad, req, bad_val, (bad_given >= len) ? 1 : 0);
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int unused_seed;
    logic [7:0] w;
    unused_seed = int'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    check(rd_data == 8'h00 && !src_sel && !pll_ready, "R1 in reset",
          int'({rd_data, src_sel, pll_ready}), 0);
    por_n = 1'b1;
    @(negedge clk);
    check(rd_data == 8'h00 && !src_sel && !pll_ready, "R1 after release",
          int'({rd_data, src_sel, pll_ready}), 0);

    // R3 reserved bits, R4 source select
    wr(8'hFF);
    check(rd_data == 8'h17, "R3 reserved read zero", rd_data, 8'h17);
    check(src_sel == 1'b1, "R4 src high", src_sel, 1);
    wr(8'h05);
    check(rd_data == 8'h05, "R2 code field", rd_data, 8'h05);
    check(src_sel == 1'b0, "R4 src low", src_sel, 0);

    // R9 software reset keeps register
    wr(8'h13);
    @(negedge clk); sw_rst = 1'b1;
    @(negedge clk); sw_rst = 1'b0;
    check(rd_data == 8'h13, "R9 kept over sw_rst", rd_data, 8'h13);

    // R5/R6/R7 every code directed
    for (int n = 0; n < 8; n++) begin
      w = 8'(n) | (8'(n & 1) << 4);
      wr(w);
      check(rd_data == exp_read(w) && src_sel == w[4], "R2 R4 code write",
            rd_data, exp_read(w));
      @(negedge clk); pll_en = 1'b1;
      wait_run(exp_len(n), 1'b0, "R5 R6 exact wait");
      @(negedge clk); pll_en = 1'b0;
      #1;
      check(pll_ready == 1'b0, "R7 drop with enable", pll_ready, 0);
    end

    // R8 write during wait does not change length
    wr(8'h05);
    @(negedge clk); pll_en = 1'b1;
    wait_run(exp_len(5), 1'b1, "R8 latched length");
    @(negedge clk); pll_en = 1'b0;

    // R10 abort mid-wait, then fresh full wait
    wr(8'h03);
    @(negedge clk); pll_en = 1'b1; ref_tick = 1'b1;
    repeat (10) @(negedge clk);
    sw_rst = 1'b1;
    @(negedge clk);
    check(pll_ready == 1'b0, "R10 abort mid-wait", pll_ready, 0);
    sw_rst = 1'b0;
    wait_run(exp_len(3), 1'b0, "R10 restart full wait");
    @(negedge clk); sw_rst = 1'b1;
    @(negedge clk);
    check(pll_ready == 1'b0, "R10 abort after done", pll_ready, 0);
    check(rd_data == 8'h03, "R9 kept after abort", rd_data, 8'h03);
    sw_rst = 1'b0; pll_en = 1'b0;

    // Random waits
    for (int k = 0; k < 12; k++) begin
      int c;
      c = int'($urandom % 8);
      w = 8'($urandom);
      w[2:0] = 3'(c);
      wr(w);
      check(rd_data == exp_read(w), "R3 random write", rd_data, exp_read(w));
      @(negedge clk); pll_en = 1'b1;
      wait_run(exp_len(c), 1'($urandom % 2), "R5 R8 random wait");
      @(negedge clk); pll_en = 1'b0;
      repeat (int'($urandom % 3)) @(negedge clk);
    end

    // R11 power-on reset clears register and ready
    wr(8'h10);
    @(negedge clk); pll_en = 1'b1; ref_tick = 1'b1;
    repeat (8) @(negedge clk);
    check(pll_ready == 1'b1, "R5 ready before por", pll_ready, 1);
    por_n = 1'b0;
    #1;
    check(rd_data == 8'h00 && !pll_ready && !src_sel, "R11 por clears",
          int'({rd_data, pll_ready, src_sel}), 0);
    @(negedge clk); por_n = 1'b1; pll_en = 1'b0; ref_tick = 1'b0;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule